// File: doc/BRIEF.md
# Receive FIFO Flow-Delay RTS Controller

This block decides the level of the active-low request-to-send pin of a serial receiver from the fill level of its receive FIFO. A programmed threshold sets a fill mark. When the FIFO fill reaches that mark, an internal trigger fires. In hardware flow-control mode the trigger makes the block deassert RTS so that the far end stops sending. RTS is asserted again only after the FIFO has drained to a point a fixed hysteresis distance below the mark. The trigger never produces an interrupt. It is seen only as a flag that the surrounding logic places in bit 12 of the channel status word.

A threshold below a minimum value turns the whole flow-delay function off. In that case the flag reads 0 and the hold state is cleared. When hardware flow-control mode is off, the pin carries the inverse of a software RTS bit. The hold state still tracks the FIFO in that mode, so switching hardware mode on reflects any pending hold at once. All outputs are registered and change one clock after the inputs that cause them.

Top module: `rx_flow_rts`

## Requirements
- R1: After reset, `rts_n` is 1 and `fd_flag` is 0.
- R2: One clock after the inputs show `thresh` >= 4 and `fill` >= `thresh`, `fd_flag` is 1. One clock after any other input combination, `fd_flag` is 0.
- R3: With `hw_fc` = 1 and `thresh` >= 4, a fill that reaches `thresh` makes `rts_n` equal 1 one clock later.
- R4: Once RTS is held off, a fill strictly between `thresh`-4 and `thresh` keeps `rts_n` at 1.
- R5: While held, a fill of `thresh`-4 or lower releases the hold, and `rts_n` is 0 one clock later when `hw_fc` = 1. A fill below `thresh` with no hold pending gives `rts_n` = 0.
- R6: A `thresh` below 4 disables the function. `fd_flag` is 0, the hold is cleared, and in hardware mode `rts_n` is 0 whatever the fill. Raising the threshold again starts without a hold.
- R7: With `hw_fc` = 0, `rts_n` is the inverse of `sw_rts` one clock later, whatever the fill.
- R8: A new `thresh` value is compared against the fill, for both the trigger and the release, on the first clock after the change. This includes the case where RTS is currently held.
- R9: The hold state keeps following the fill while `hw_fc` = 0. Turning `hw_fc` on with a pending hold gives `rts_n` = 1 at once, one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fill | input | 6 | Current receive FIFO fill count |
| thresh | input | 6 | Programmed flow-delay threshold |
| hw_fc | input | 1 | Hardware flow-control mode enable |
| sw_rts | input | 1 | Software RTS request (1 = assert) |
| rts_n | output | 1 | Active-low request-to-send pin |
| fd_flag | output | 1 | Flow-delay trigger status flag |

## Verification
The hardest situation to reach from the ports is a fill inside the hysteresis band, where the correct output depends on history and not on the current inputs. The stimulus gets there by overfilling first and then draining one step at a time, so that each band value is seen while a hold is pending. It also makes the same band values appear on a rising fill, where no hold is pending. A second hard case is a hold that is set while software mode is active and only shows up once hardware mode is switched on. Threshold changes while held (raising the threshold above the fill, and dropping it below the enable minimum) exercise the re-evaluation and clearing paths.

// File: rtl/rxfd_pkg.sv
package rxfd_pkg;
   typedef enum logic {
      GATE_OPEN = 1'b0,
      GATE_HELD = 1'b1
   } gate_e;
endpackage

// File: rtl/rxfd_cmp.sv
module rxfd_cmp #(
   parameter int W       = 6,
   parameter int HYST    = 4,
   parameter int MIN_THR = 4
) (
   input  logic [W-1:0] fill,
   input  logic [W-1:0] thresh,
   output logic         en,
   output logic         trig,
   output logic         rel
);
   localparam int XW = W + 1;
   localparam logic [XW-1:0] HYST_X = XW'(HYST);

   logic [XW-1:0] fill_x;
   logic [XW-1:0] thr_x;

   assign fill_x = {1'b0, fill};
   assign thr_x  = {1'b0, thresh};

   generate
      if (MIN_THR > 0) begin : g_gate
         localparam logic [W-1:0] MIN_V = W'(MIN_THR);
         assign en = (thresh >= MIN_V);
      end else begin : g_always
         assign en = 1'b1;
      end
   endgenerate

   assign trig = (fill >= thresh);
   assign rel  = ((fill_x + HYST_X) <= thr_x);
endmodule

// File: rtl/rxfd_hold.sv
module rxfd_hold
   import rxfd_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  en,
   input  logic  trig,
   input  logic  rel,
   output gate_e held_d,
   output gate_e held_q
);
   always_comb begin
      held_d = held_q;
      if (!en)       held_d = GATE_OPEN;
      else if (trig) held_d = GATE_HELD;
      else if (rel)  held_d = GATE_OPEN;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) held_q <= GATE_OPEN;
      else        held_q <= held_d;
   end

   // R6
   hold_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> held_q == GATE_OPEN);
   // R3
   hold_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && trig) |=> held_q == GATE_HELD);
   // R4
   hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !trig && !rel) |=> held_q == $past(held_q));
endmodule

// File: rtl/rxfd_out.sv
module rxfd_out
   import rxfd_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  hw_fc,
   input  logic  sw_rts,
   input  logic  flag_d,
   input  gate_e held_d,
   output logic  rts_n,
   output logic  fd_flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rts_n   <= 1'b1;
         fd_flag <= 1'b0;
      end else begin
         rts_n   <= hw_fc ? (held_d == GATE_HELD) : ~sw_rts;
         fd_flag <= flag_d;
      end
   end

   // R7
   sw_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hw_fc |=> rts_n == !$past(sw_rts));
   // R2
   flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flag_d |=> fd_flag);
   // R2
   flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !flag_d |=> !fd_flag);
endmodule

// File: rtl/rx_flow_rts.sv
module rx_flow_rts
   import rxfd_pkg::*;
#(
   parameter int W       = 6,
   parameter int HYST    = 4,
   parameter int MIN_THR = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] fill,
   input  logic [W-1:0] thresh,
   input  logic         hw_fc,
   input  logic         sw_rts,
   output logic         rts_n,
   output logic         fd_flag
);
   localparam int MAXV = (1 << W) - 1;

   generate
      if (W < 2)           begin : g_bad_w   $error("W too small");            end
      if (HYST < 1)        begin : g_bad_h   $error("HYST must be positive");  end
      if (HYST > MAXV)     begin : g_bad_h2  $error("HYST exceeds range");     end
      if (MIN_THR > MAXV)  begin : g_bad_m   $error("MIN_THR exceeds range");  end
   endgenerate

   logic  en, trig, rel;
   gate_e held_d, held_q;

   rxfd_cmp #(.W(W), .HYST(HYST), .MIN_THR(MIN_THR)) u_cmp (
      .fill   (fill),
      .thresh (thresh),
      .en     (en),
      .trig   (trig),
      .rel    (rel)
   );

   rxfd_hold u_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (en),
      .trig   (trig),
      .rel    (rel),
      .held_d (held_d),
      .held_q (held_q)
   );

   rxfd_out u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .hw_fc   (hw_fc),
      .sw_rts  (sw_rts),
      .flag_d  (en && trig),
      .held_d  (held_d),
      .rts_n   (rts_n),
      .fd_flag (fd_flag)
   );

   // R5
   release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_fc && held_q == GATE_HELD && rel) |=> !rts_n);
   // R3
   block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_fc && en && trig) |=> rts_n);
endmodule

// File: tb/tb_rx_flow_rts.sv
module tb_rx_flow_rts;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] fill = '0;
   logic [5:0] thresh = '0;
   logic       hw_fc = 1'b0;
   logic       sw_rts = 1'b0;
   logic       rts_n, fd_flag;
   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   rx_flow_rts dut (
      .clk(clk), .rst_n(rst_n), .fill(fill), .thresh(thresh),
      .hw_fc(hw_fc), .sw_rts(sw_rts), .rts_n(rts_n), .fd_flag(fd_flag)
   );

   task automatic chk(input logic er, input logic ef, input string tag);
      checks++;
      if (rts_n !== er || fd_flag !== ef) begin
         errors++;
         $display("FAIL %s: rts_n=%b fd_flag=%b expected rts_n=%b fd_flag=%b",
                  tag, rts_n, fd_flag, er, ef);
      end
   endtask

   task automatic step(input int f, input int t, input logic hw, input logic sw,
                       input logic er, input logic ef, input string tag);
      @(negedge clk);
      fill = 6'(f); thresh = 6'(t); hw_fc = hw; sw_rts = sw;
      @(negedge clk);
      chk(er, ef, tag);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      fill = 6'd63; thresh = 6'd20; hw_fc = 1'b1;
      repeat (2) @(negedge clk);
      chk(1'b1, 1'b0, "R1 reset");
      fill = 6'd0;
      rst_n = 1'b1;
   endtask

   task automatic t_hyst();
      step(19, 20, 1, 0, 0, 0, "R2 below threshold");
      step(20, 20, 1, 0, 1, 1, "R3 reach threshold");
      step(25, 20, 1, 0, 1, 1, "R2 above threshold");
      step(19, 20, 1, 0, 1, 0, "R4 band 19");
      step(17, 20, 1, 0, 1, 0, "R4 band 17");
      step(16, 20, 1, 0, 0, 0, "R5 release at thr-4");
      step(18, 20, 1, 0, 0, 0, "R5 rising band no hold");
   endtask

   task automatic t_edges();
      step(4, 4, 1, 0, 1, 1, "R3 min threshold");
      step(1, 4, 1, 0, 1, 0, "R4 min threshold band");
      step(0, 4, 1, 0, 0, 0, "R5 min threshold release");
      step(63, 63, 1, 0, 1, 1, "R3 max threshold");
      step(60, 63, 1, 0, 1, 0, "R4 max threshold band");
      step(59, 63, 1, 0, 0, 0, "R5 max threshold release");
   endtask

   task automatic t_disable();
      step(63, 3, 1, 0, 0, 0, "R6 disabled threshold 3");
      step(30, 20, 1, 0, 1, 1, "R3 set hold");
      step(30, 2, 1, 0, 0, 0, "R6 disable while held");
      step(18, 20, 1, 0, 0, 0, "R6 hold cleared on re-enable");
   endtask

   task automatic t_rethr();
      step(30, 20, 1, 0, 1, 1, "R8 set hold");
      step(30, 40, 1, 0, 0, 0, "R8 raise threshold releases");
      step(10, 20, 1, 0, 0, 0, "R8 below");
      step(10, 10, 1, 0, 1, 1, "R8 lower threshold triggers");
   endtask

   task automatic t_soft();
      step(63, 20, 0, 1, 0, 1, "R7 sw assert ignores fill");
      step(63, 20, 0, 0, 1, 1, "R7 sw deassert");
      step(0, 20, 0, 1, 0, 0, "R7 sw assert empty");
      step(30, 20, 0, 1, 0, 1, "R9 hold set in sw mode");
      step(18, 20, 0, 1, 0, 0, "R9 band in sw mode");
      step(18, 20, 1, 1, 1, 0, "R9 hw on shows hold");
      step(16, 20, 1, 1, 0, 0, "R9 release after hw on");
   endtask

   initial begin
      t_reset();
      t_hyst();
      t_edges();
      t_disable();
      t_rethr();
      t_soft();
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog: done=0 expected done=1");
         end
      join_any
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule